// File: doc/BRIEF.md
# Host Port Access Controller for a Two-Way FIFO

This block is the control logic behind the host side of a two-direction FIFO device. On each rising clock edge it decodes an active-low chip select, a 3-bit address, a read/write line and an active-low enable. From these it issues one-cycle strobes toward the outbound FIFO, the inbound FIFO and the bypass mailbox, and it loads one of four flag-offset registers.

A single registered output word carries the data read from the inbound FIFO head, the inbound bypass mailbox, or the readback of an offset register. That word holds whenever no read is clocked. A separate drive enable tells the pad logic when the host data bus may be driven.

The block also keeps the bus released for one read-direction cycle after any clocked write. This lets the host turn the bus around safely. The FIFO storage and the pads belong to neighbouring blocks.

Top module: `hostport_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the output register to 0, sets all four offset registers to DEFAULT_OFS (8), and leaves the drive enable low.
- R2: With cs_n low, en_n low, rw low and address 000, fifo_wr_stb is high in that cycle and wr_data equals din. No other strobe is high.
- R3: With cs_n low, en_n low, rw high and address 000, fifo_rd_stb is high in that cycle. After the edge the output register holds the value of in_fifo_data.
- R4: Address 001 selects the bypass path, and byp_sel is high whenever cs_n is low with this address. A clocked write pulses byp_wr_stb. A clocked read pulses byp_rd_stb and loads in_byp_data into the output register.
- R5: A clocked write with address 1xx stores din[8:0] into one offset register, and the other three hold. Address 100 selects the outbound almost-empty offset, 101 the outbound almost-full offset, 110 the inbound almost-empty offset and 111 the inbound almost-full offset.
- R6: A clocked read with address 1xx loads the selected offset into the output register, zero-extended to 18 bits.
- R7: With en_n high, nothing is strobed, the output register holds and no offset register changes, whatever the address and direction.
- R8: With cs_n high, the port is idle: no strobe, byp_sel low, drive enable low, and the output register and offsets hold.
- R9: drive_en is high only when cs_n is low, rw is high and oe_n is low, and no write is pending release (see R10).
- R10: After a clocked write (cs_n, rw and en_n all low), drive_en stays low during the next cycle with rw high, even with oe_n low. It returns once an edge has been clocked with cs_n low and rw high.
- R11: Addresses 010 and 011 are reserved. Accesses to them raise no strobe, load nothing into the output register and change no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host port clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 3 | Resource address |
| rw | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Transfer enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Host write data |
| in_fifo_data | input | 18 | Head word of the inbound FIFO |
| in_byp_data | input | 18 | Inbound bypass mailbox word |
| dout | output | 18 | Host output register |
| drive_en | output | 1 | Bus drive enable toward the pads |
| wr_data | output | 18 | Write data toward FIFO and mailbox |
| fifo_wr_stb | output | 1 | Outbound FIFO push strobe |
| fifo_rd_stb | output | 1 | Inbound FIFO pop strobe |
| byp_wr_stb | output | 1 | Outbound mailbox write strobe |
| byp_rd_stb | output | 1 | Inbound mailbox read strobe |
| byp_sel | output | 1 | Bypass mode selected |
| ob_ae_ofs | output | 9 | Outbound almost-empty offset |
| ob_af_ofs | output | 9 | Outbound almost-full offset |
| ib_ae_ofs | output | 9 | Inbound almost-empty offset |
| ib_af_ofs | output | 9 | Inbound almost-full offset |

## Verification
The bus-release rule and the output-register load can fall on the same edge. This happens when the first read-direction cycle after a write is itself a clocked read. The bench provokes it by writing through the FIFO address and then reading an offset register on the next cycle with oe_n low. It requires drive_en to be low during that cycle, yet the output register must still hold the zero-extended offset after the edge. A further cycle in the read direction must raise drive_en.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int ADDR_W = 3;
  localparam int N_OFS  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_FIFO  = 3'b000,
    A_BYP   = 3'b001,
    A_RSV0  = 3'b010,
    A_RSV1  = 3'b011,
    A_OB_AE = 3'b100,
    A_OB_AF = 3'b101,
    A_IB_AE = 3'b110,
    A_IB_AF = 3'b111
  } hp_addr_e;

  typedef struct packed {
    logic       fifo_wr;
    logic       fifo_rd;
    logic       byp_wr;
    logic       byp_rd;
    logic       ofs_wr;
    logic       ofs_rd;
    logic [1:0] ofs_idx;
    logic       byp_mode;
    logic       any_wr;
    logic       rd_dir;
  } hp_dec_t;
endpackage

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
(
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              en_n,
  output hp_dec_t           dec
);
  logic sel, xfer_w, xfer_r;
  logic is_fifo, is_byp, is_ofs;

  always_comb begin
    sel     = ~cs_n;
    xfer_w  = sel & ~en_n & ~rw;
    xfer_r  = sel & ~en_n & rw;
    is_fifo = (addr == A_FIFO);
    is_byp  = (addr == A_BYP);
    is_ofs  = addr[2];

    dec          = '0;
    dec.fifo_wr  = xfer_w & is_fifo;
    dec.fifo_rd  = xfer_r & is_fifo;
    dec.byp_wr   = xfer_w & is_byp;
    dec.byp_rd   = xfer_r & is_byp;
    dec.ofs_wr   = xfer_w & is_ofs;
    dec.ofs_rd   = xfer_r & is_ofs;
    dec.ofs_idx  = addr[1:0];
    dec.byp_mode = sel & is_byp;
    dec.any_wr   = xfer_w;
    dec.rd_dir   = sel & rw;
  end
endmodule

// File: rtl/hp_offset_regs.sv
module hp_offset_regs #(
  parameter int OFS_W       = 9,
  parameter int N_REG       = 4,
  parameter int DEFAULT_OFS = 8,
  localparam int IDX_W      = $clog2(N_REG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [IDX_W-1:0]            idx,
  input  logic [OFS_W-1:0]            wdata,
  output logic [N_REG-1:0][OFS_W-1:0] q
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT_OFS);

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= RST_VAL;
      else if (wr && (idx == IDX_W'(g)))
        q[g] <= wdata;
    end
  end
endmodule

// File: rtl/hp_out_reg.sv
module hp_out_reg
  import hp_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  hp_dec_t                     dec,
  input  logic [DATA_W-1:0]           fifo_data,
  input  logic [DATA_W-1:0]           byp_data,
  input  logic [N_OFS-1:0][OFS_W-1:0] ofs,
  output logic [DATA_W-1:0]           q
);
  localparam int PAD_W = DATA_W - OFS_W;

  logic              load;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    load = dec.fifo_rd | dec.byp_rd | dec.ofs_rd;
    if (dec.fifo_rd)      nxt = fifo_data;
    else if (dec.byp_rd)  nxt = byp_data;
    else                  nxt = {{PAD_W{1'b0}}, ofs[dec.ofs_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= nxt;
  end
endmodule

// File: rtl/hp_drive_ctl.sv
module hp_drive_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rw,
  input  logic oe_n,
  input  logic any_wr,
  input  logic rd_dir,
  output logic drive_en
);
  logic hold_hiz;

  always_ff @(posedge clk) begin
    if (rst)         hold_hiz <= 1'b0;
    else if (any_wr) hold_hiz <= 1'b1;
    else if (rd_dir) hold_hiz <= 1'b0;
  end

  assign drive_en = ~cs_n & rw & ~oe_n & ~hold_hiz;
endmodule

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
  import hp_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 9,
  parameter int DEFAULT_OFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [2:0]        addr,
  input  logic              rw,
  input  logic              en_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] in_fifo_data,
  input  logic [DATA_W-1:0] in_byp_data,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              fifo_wr_stb,
  output logic              fifo_rd_stb,
  output logic              byp_wr_stb,
  output logic              byp_rd_stb,
  output logic              byp_sel,
  output logic [OFS_W-1:0]  ob_ae_ofs,
  output logic [OFS_W-1:0]  ob_af_ofs,
  output logic [OFS_W-1:0]  ib_ae_ofs,
  output logic [OFS_W-1:0]  ib_af_ofs
);
  hp_dec_t                     dec;
  logic [N_OFS-1:0][OFS_W-1:0] ofs_q;

  hp_decode u_dec (
    .cs_n (cs_n),
    .addr (addr),
    .rw   (rw),
    .en_n (en_n),
    .dec  (dec)
  );

  hp_offset_regs #(
    .OFS_W       (OFS_W),
    .N_REG       (N_OFS),
    .DEFAULT_OFS (DEFAULT_OFS)
  ) u_ofs (
    .clk   (clk),
    .rst   (rst),
    .wr    (dec.ofs_wr),
    .idx   (dec.ofs_idx),
    .wdata (din[OFS_W-1:0]),
    .q     (ofs_q)
  );

  hp_out_reg #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .fifo_data (in_fifo_data),
    .byp_data  (in_byp_data),
    .ofs       (ofs_q),
    .q         (dout)
  );

  hp_drive_ctl u_drv (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rw       (rw),
    .oe_n     (oe_n),
    .any_wr   (dec.any_wr),
    .rd_dir   (dec.rd_dir),
    .drive_en (drive_en)
  );

  assign wr_data     = din;
  assign fifo_wr_stb = dec.fifo_wr;
  assign fifo_rd_stb = dec.fifo_rd;
  assign byp_wr_stb  = dec.byp_wr;
  assign byp_rd_stb  = dec.byp_rd;
  assign byp_sel     = dec.byp_mode;
  assign ob_ae_ofs   = ofs_q[0];
  assign ob_af_ofs   = ofs_q[1];
  assign ib_ae_ofs   = ofs_q[2];
  assign ib_af_ofs   = ofs_q[3];
endmodule

// File: rtl/hostport_ctrl_chk.sv
module hostport_ctrl_chk #(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [2:0]        addr,
  input logic              rw,
  input logic              en_n,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] in_fifo_data,
  input logic [DATA_W-1:0] dout,
  input logic              drive_en,
  input logic              fifo_wr_stb,
  input logic              fifo_rd_stb,
  input logic              byp_wr_stb,
  input logic              byp_rd_stb,
  input logic              byp_sel,
  input logic [OFS_W-1:0]  ob_ae_ofs
);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_wr_stb, fifo_rd_stb, byp_wr_stb, byp_rd_stb}));

  a_r8_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !(fifo_wr_stb || fifo_rd_stb || byp_wr_stb || byp_rd_stb || byp_sel || drive_en));

  a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    en_n |=> $stable(dout));

  a_r3_fifo_read_loads: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_stb |=> (dout == $past(in_fifo_data)));

  a_r10_release_after_write: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rw && !en_n) |=> !drive_en);

  a_r5_ob_ae_write: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rw && !en_n && addr == 3'b100) |=> (ob_ae_ofs == $past(din[OFS_W-1:0])));
endmodule

bind hostport_ctrl hostport_ctrl_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .addr         (addr),
  .rw           (rw),
  .en_n         (en_n),
  .din          (din),
  .in_fifo_data (in_fifo_data),
  .dout         (dout),
  .drive_en     (drive_en),
  .fifo_wr_stb  (fifo_wr_stb),
  .fifo_rd_stb  (fifo_rd_stb),
  .byp_wr_stb   (byp_wr_stb),
  .byp_rd_stb   (byp_rd_stb),
  .byp_sel      (byp_sel),
  .ob_ae_ofs    (ob_ae_ofs)
);

// File: tb/hostport_ctrl_tb.sv
module hostport_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DW = 18;
  localparam int OW = 9;
  localparam logic [DW-1:0] FIFO_SRC = 18'h2A001;
  localparam logic [DW-1:0] BYP_SRC  = 18'h15002;
  localparam int NV = 21;

  // {cs_n, addr[3], rw, en_n, din[18], strobes{fwr,frd,bwr,brd}, dout_after[18]}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 18'h00003, 4'b1000, 18'h00000}, // R2 fifo write
    {1'b0, 3'd0, 1'b1, 1'b0, 18'h00000, 4'b0100, 18'h2A001}, // R3 fifo read
    {1'b0, 3'd1, 1'b1, 1'b0, 18'h00000, 4'b0001, 18'h15002}, // R4 bypass read
    {1'b0, 3'd1, 1'b0, 1'b0, 18'h00005, 4'b0010, 18'h15002}, // R4 bypass write
    {1'b0, 3'd4, 1'b0, 1'b0, 18'h3FF05, 4'b0000, 18'h15002}, // R5 ob ae
    {1'b0, 3'd5, 1'b0, 1'b0, 18'h00021, 4'b0000, 18'h15002}, // R5 ob af
    {1'b0, 3'd6, 1'b0, 1'b0, 18'h00044, 4'b0000, 18'h15002}, // R5 ib ae
    {1'b0, 3'd7, 1'b0, 1'b0, 18'h201FF, 4'b0000, 18'h15002}, // R5 ib af
    {1'b0, 3'd4, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00105}, // R6
    {1'b0, 3'd5, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00021}, // R6
    {1'b0, 3'd6, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00044}, // R6
    {1'b0, 3'd7, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h001FF}, // R6
    {1'b0, 3'd0, 1'b1, 1'b1, 18'h00000, 4'b0000, 18'h001FF}, // R7 read held
    {1'b1, 3'd0, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h001FF}, // R8 deselected read
    {1'b1, 3'd4, 1'b0, 1'b0, 18'h00000, 4'b0000, 18'h001FF}, // R8 deselected write
    {1'b0, 3'd4, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00105}, // R8 offset intact
    {1'b0, 3'd2, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00105}, // R11 reserved read
    {1'b0, 3'd3, 1'b0, 1'b0, 18'h00000, 4'b0000, 18'h00105}, // R11 reserved write
    {1'b0, 3'd7, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h001FF}, // R11 offsets intact
    {1'b0, 3'd4, 1'b0, 1'b1, 18'h00000, 4'b0000, 18'h001FF}, // R7 write held
    {1'b0, 3'd4, 1'b1, 1'b0, 18'h00000, 4'b0000, 18'h00105}  // R7 offset intact
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rw = 1'b1, en_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = 3'd0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, wr_data;
  logic drive_en, fifo_wr_stb, fifo_rd_stb, byp_wr_stb, byp_rd_stb, byp_sel;
  logic [OW-1:0] ob_ae_ofs, ob_af_ofs, ib_ae_ofs, ib_af_ofs;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hostport_ctrl u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rw(rw), .en_n(en_n),
    .oe_n(oe_n), .din(din), .in_fifo_data(FIFO_SRC), .in_byp_data(BYP_SRC),
    .dout(dout), .drive_en(drive_en), .wr_data(wr_data),
    .fifo_wr_stb(fifo_wr_stb), .fifo_rd_stb(fifo_rd_stb),
    .byp_wr_stb(byp_wr_stb), .byp_rd_stb(byp_rd_stb), .byp_sel(byp_sel),
    .ob_ae_ofs(ob_ae_ofs), .ob_af_ofs(ob_af_ofs),
    .ib_ae_ofs(ib_ae_ofs), .ib_af_ofs(ib_af_ofs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_neg();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    next_neg();
    rst = 1'b0;
    // R1 reset state
    chk("R1 dout", 32'(dout), 0);
    chk("R1 ob_ae", 32'(ob_ae_ofs), 8);
    chk("R1 ob_af", 32'(ob_af_ofs), 8);
    chk("R1 ib_ae", 32'(ib_ae_ofs), 8);
    chk("R1 ib_af", 32'(ib_af_ofs), 8);
    chk("R1 drive_en", 32'(drive_en), 0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      cs_n = v[45]; addr = v[44:42]; rw = v[41]; en_n = v[40]; din = v[39:22];
      #1;
      chk("R2/R3/R4/R7/R8/R11 strobes",
          32'({fifo_wr_stb, fifo_rd_stb, byp_wr_stb, byp_rd_stb}), 32'(v[21:18]));
      chk("R4/R8 byp_sel", 32'(byp_sel), 32'(!v[45] && v[44:42] == 3'd1));
      if (!v[45] && !v[41] && !v[40]) chk("R2 wr_data", 32'(wr_data), 32'(v[39:22]));
      next_neg();
      chk("R3/R4/R6/R7/R8/R11 dout", 32'(dout), 32'(v[17:0]));
    end
    chk("R5 ob_ae", 32'(ob_ae_ofs), 32'h105);
    chk("R5 ob_af", 32'(ob_af_ofs), 32'h021);
    chk("R5 ib_ae", 32'(ib_ae_ofs), 32'h044);
    chk("R5 ib_af", 32'(ib_af_ofs), 32'h1FF);

    // drive enable rules
    cs_n = 1'b0; rw = 1'b1; en_n = 1'b1; oe_n = 1'b0; addr = 3'd0;
    next_neg();
    chk("R9 drive on", 32'(drive_en), 1);
    oe_n = 1'b1; #1;
    chk("R9 oe_n high", 32'(drive_en), 0);
    oe_n = 1'b0; cs_n = 1'b1; #1;
    chk("R8 drive off when deselected", 32'(drive_en), 0);
    cs_n = 1'b0; rw = 1'b0; en_n = 1'b0; din = 18'h00009; #1;
    chk("R9 write direction", 32'(drive_en), 0);
    next_neg();
    // turnaround cycle: clocked offset read while bus released
    rw = 1'b1; en_n = 1'b0; addr = 3'd5; #1;
    chk("R10 released after write", 32'(drive_en), 0);
    next_neg();
    chk("R10/R6 load during release", 32'(dout), 32'h021);
    en_n = 1'b1; #1;
    chk("R10 drive restored", 32'(drive_en), 1);

    // reset mid-run
    rst = 1'b1;
    next_neg();
    rst = 1'b0; cs_n = 1'b1;
    #1;
    chk("R1 dout after reset", 32'(dout), 0);
    chk("R1 ob_ae after reset", 32'(ob_ae_ofs), 8);
    chk("R1 ib_af after reset", 32'(ib_af_ofs), 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule